// File: doc/BRIEF.md
# FIFO Threshold Interrupt and DMA Request Controller

This block sits beside a pair of 64-entry byte FIFOs, one feeding a serial transmitter and one filled by a serial receiver. It does not hold any data. It watches the fill level of each FIFO, together with the receive-side read strobe and the transmit-side write strobe, and drives four request lines: a receive interrupt, a transmit interrupt, a receive DMA request and a transmit DMA request. Every output is registered, so it reflects the inputs sampled at the previous rising clock edge.

The interrupt lines are pure level comparisons against a programmed trigger. The DMA lines add hysteresis. Once a DMA request is raised, it stays up until a full burst has been moved, measured in strobes. The receive burst length is the receive trigger. The transmit burst length is the transmit trigger space. The transmit DMA threshold is normally the FIFO depth minus the trigger space. An explicit threshold may be selected instead, and it is forced to the depth when it would overrun the FIFO.

The trigger and threshold settings are captured only while the FIFOs are disabled. With the FIFOs disabled, the block falls back to single-character operation, and a zero DMA mode keeps both DMA lines quiet.

Top module: `fifo_req_ctrl`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. After reset the captured receive trigger and transmit space are 1, explicit-threshold mode is off, and the captured explicit threshold is 0.
- R2: With `fifo_en`=1, `rx_irq` is 1 exactly when `rx_level` is at or above the captured receive trigger. This uses the values sampled at the previous rising edge.
- R3: With `fifo_en`=1, `tx_irq` is 1 exactly when `tx_level` is below the captured transmit space. An empty FIFO therefore always raises it.
- R4: The receive DMA request rises when `rx_level` reaches the receive trigger. It falls on the edge that samples the trigger-th `rx_pop` counted since it rose. It is re-evaluated on the following edge.
- R5: With explicit mode off, the transmit DMA threshold is 64 minus the transmit space. The transmit DMA request rises when `tx_level` is below that threshold.
- R6: With explicit mode on, the threshold is the captured `tx_thr_set` value. If that value plus the transmit space exceeds 64, the threshold is 64 instead.
- R7: Once raised, the transmit DMA request stays at 1 whatever `tx_level` does. It falls only on the edge that samples the space-th `tx_push` counted since it rose.
- R8: With `fifo_en`=0, the block works in single-character mode, with trigger, space and threshold all set to 1. The receive interrupt and DMA request follow `rx_level`≥1, and the DMA request drops after one pop. The transmit interrupt and DMA request follow `tx_level`=0, and the DMA request drops after one push.
- R9: When `dma_mode` is 0, both DMA request lines are 0 on the next edge, and the burst state returns to idle. Any value from 1 to 3 enables the DMA lines.
- R10: The settings inputs are captured only on edges where `fifo_en` is 0. Changes made while it is 1 have no effect.
- R11: A trigger or space setting of 0 is captured as 1, and a setting above 64 is captured as 64.
- R12: A change of `fifo_en` drops any DMA burst in progress. The request is then re-evaluated from idle on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable; 0 selects single-character mode |
| dma_mode | input | 2 | DMA mode; 0 silences both DMA request lines |
| rx_trig_set | input | 7 | Receive trigger level setting |
| tx_space_set | input | 7 | Transmit trigger space setting |
| tx_thr_explicit | input | 1 | Selects the explicit transmit DMA threshold |
| tx_thr_set | input | 7 | Explicit transmit DMA threshold value |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO fill level, 0 to 64 |
| rx_pop | input | 1 | One receive FIFO entry read this cycle |
| tx_push | input | 1 | One transmit FIFO entry written this cycle |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench checks the comparison boundaries on both sides of each threshold: level 7 against level 8 for a trigger of 8, and 47 against 48 for a derived threshold of 48. An off-by-one comparison would flip one of those results. It counts a burst out strobe by strobe, with the level held above threshold. A design that dropped the request on level instead of on strobe count, or that ended the burst one strobe early, would release a line that must stay up. It programs an explicit threshold whose sum with the space overruns the FIFO; a design without the clamp would leave the transmit request low at level 63. It also changes the settings while enabled and writes out-of-range values of 0 and 100. A design that captured settings at the wrong time, or that did not clamp them, would move the receive interrupt boundary.

// File: rtl/fqr_pkg.sv
package fqr_pkg;

  // Force a trigger or space setting into the legal range 1..depth.
  function automatic int clamp_trig(input int raw, input int depth);
    if (raw == 0) return 1;
    if (raw > depth) return depth;
    return raw;
  endfunction

  // Transmit DMA threshold: derived from the space, or explicit with a clamp.
  function automatic int tx_dma_threshold(input bit explicit_on, input int thr,
                                          input int space, input int depth);
    if (!explicit_on) return depth - space;
    if (thr + space > depth) return depth;
    return thr;
  endfunction

endpackage

// File: rtl/fqr_cfg_hold.sv
module fqr_cfg_hold #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] rx_trig_raw,
  input  logic [LW-1:0] space_raw,
  input  logic          explicit_raw,
  input  logic [LW-1:0] thr_raw,
  output logic [LW-1:0] rx_trig_q,
  output logic [LW-1:0] space_q,
  output logic          explicit_q,
  output logic [LW-1:0] thr_q
);

  logic [LW-1:0] rx_trig_lim;
  logic [LW-1:0] space_lim;

  assign rx_trig_lim = LW'(fqr_pkg::clamp_trig(int'(rx_trig_raw), DEPTH));
  assign space_lim   = LW'(fqr_pkg::clamp_trig(int'(space_raw), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_trig_q  <= LW'(1);
      space_q    <= LW'(1);
      explicit_q <= 1'b0;
      thr_q      <= '0;
    end else if (load) begin
      rx_trig_q  <= rx_trig_lim;
      space_q    <= space_lim;
      explicit_q <= explicit_raw;
      thr_q      <= thr_raw;
    end
  end

endmodule

// File: rtl/fqr_level_flag.sv
module fqr_level_flag #(
  parameter int LW    = 7,
  parameter bit ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thr,
  output logic          flag
);

  logic hit;

  generate
    if (ABOVE) begin : g_at_or_above
      assign hit = (level >= thr);
    end else begin : g_below
      assign hit = (level < thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= hit;
  end

endmodule

// File: rtl/fqr_burst_req.sv
module fqr_burst_req #(
  parameter int LW    = 7,
  parameter bit ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thr,
  input  logic [LW-1:0] target,
  input  logic          strobe,
  output logic          req,
  output logic          burst_done
);

  logic          act_q, act_d, act_cur, cond;
  logic [LW-1:0] cnt_q, cnt_d, cnt_inc;

  generate
    if (ABOVE) begin : g_at_or_above
      assign cond = (level >= thr);
    end else begin : g_below
      assign cond = (level < thr);
    end
  endgenerate

  assign act_cur    = act_q && !restart;
  assign cnt_inc    = cnt_q + LW'(1);
  assign burst_done = act_cur && run && strobe && (cnt_inc >= target);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (!run) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (!act_cur) begin
      act_d = cond;
      cnt_d = '0;
    end else if (strobe) begin
      if (cnt_inc >= target) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign req = act_q;

endmodule

// File: rtl/fifo_req_ctrl.sv
module fifo_req_ctrl #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    dma_mode,
  input  logic [LW-1:0] rx_trig_set,
  input  logic [LW-1:0] tx_space_set,
  input  logic          tx_thr_explicit,
  input  logic [LW-1:0] tx_thr_set,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          rx_pop,
  input  logic          tx_push,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          rx_dma_req,
  output logic          tx_dma_req
);

  logic [LW-1:0] rx_trig_q, tx_space_q, tx_thr_q;
  logic          tx_explicit_q;
  logic          en_q;
  logic          mode_flip;
  logic          dma_run;
  logic [LW-1:0] tx_thr_calc;
  logic [LW-1:0] eff_rx_trig, eff_tx_space, eff_tx_thr;
  logic          rx_burst_done, tx_burst_done;

  // Settings are captured only while the FIFOs are disabled (R10, R11).
  fqr_cfg_hold #(.DEPTH(DEPTH), .LW(LW)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (!fifo_en),
    .rx_trig_raw  (rx_trig_set),
    .space_raw    (tx_space_set),
    .explicit_raw (tx_thr_explicit),
    .thr_raw      (tx_thr_set),
    .rx_trig_q    (rx_trig_q),
    .space_q      (tx_space_q),
    .explicit_q   (tx_explicit_q),
    .thr_q        (tx_thr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign mode_flip   = (fifo_en != en_q);
  assign dma_run     = (dma_mode != 2'd0);
  assign tx_thr_calc = LW'(fqr_pkg::tx_dma_threshold(tx_explicit_q, int'(tx_thr_q),
                                                     int'(tx_space_q), DEPTH));

  // Single-character mode collapses every setting to one (R8).
  assign eff_rx_trig  = fifo_en ? rx_trig_q   : LW'(1);
  assign eff_tx_space = fifo_en ? tx_space_q  : LW'(1);
  assign eff_tx_thr   = fifo_en ? tx_thr_calc : LW'(1);

  fqr_level_flag #(.LW(LW), .ABOVE(1'b1)) u_rx_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .level (rx_level),
    .thr   (eff_rx_trig),
    .flag  (rx_irq)
  );

  fqr_level_flag #(.LW(LW), .ABOVE(1'b0)) u_tx_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .level (tx_level),
    .thr   (eff_tx_space),
    .flag  (tx_irq)
  );

  fqr_burst_req #(.LW(LW), .ABOVE(1'b1)) u_rx_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (dma_run),
    .restart    (mode_flip),
    .level      (rx_level),
    .thr        (eff_rx_trig),
    .target     (eff_rx_trig),
    .strobe     (rx_pop),
    .req        (rx_dma_req),
    .burst_done (rx_burst_done)
  );

  fqr_burst_req #(.LW(LW), .ABOVE(1'b0)) u_tx_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (dma_run),
    .restart    (mode_flip),
    .level      (tx_level),
    .thr        (eff_tx_thr),
    .target     (eff_tx_space),
    .strobe     (tx_push),
    .req        (tx_dma_req),
    .burst_done (tx_burst_done)
  );

endmodule

// File: rtl/fqr_checker.sv
module fqr_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic [1:0]    dma_mode,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          rx_pop,
  input logic          tx_push,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          rx_dma_req,
  input logic          tx_dma_req,
  input logic [LW-1:0] eff_rx_trig,
  input logic [LW-1:0] rx_trig_hold,
  input logic          rx_burst_done,
  input logic          tx_burst_done
);

  p_rx_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (rx_level >= eff_rx_trig)) |=> rx_irq);

  p_tx_irq_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |=> tx_irq);

  p_rx_dma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_req && !rx_pop && (dma_mode != 2'd0) && $stable(fifo_en)) |=> rx_dma_req);

  p_rx_dma_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_burst_done |=> !rx_dma_req);

  p_tx_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req && !tx_push && (dma_mode != 2'd0) && $stable(fifo_en)) |=> tx_dma_req);

  p_tx_dma_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_burst_done |=> !tx_dma_req);

  p_single_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && (rx_level == '0)) |=> !rx_irq);

  p_dma_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode == 2'd0) |=> (!rx_dma_req && !tx_dma_req));

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |=> $stable(rx_trig_hold));

  p_trig_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_trig_hold != '0));

endmodule

bind fifo_req_ctrl fqr_checker #(.LW(LW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_en       (fifo_en),
  .dma_mode      (dma_mode),
  .rx_level      (rx_level),
  .tx_level      (tx_level),
  .rx_pop        (rx_pop),
  .tx_push       (tx_push),
  .rx_irq        (rx_irq),
  .tx_irq        (tx_irq),
  .rx_dma_req    (rx_dma_req),
  .tx_dma_req    (tx_dma_req),
  .eff_rx_trig   (eff_rx_trig),
  .rx_trig_hold  (rx_trig_q),
  .rx_burst_done (rx_burst_done),
  .tx_burst_done (tx_burst_done)
);

// File: tb/sim_fifo_req_ctrl.sv
module sim_fifo_req_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic [1:0] dma_mode;
  logic [6:0] rx_trig_set, tx_space_set, tx_thr_set;
  logic       tx_thr_explicit;
  logic [6:0] rx_level, tx_level;
  logic       rx_pop, tx_push;
  logic       rx_irq, tx_irq, rx_dma_req, tx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fifo_req_ctrl u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .fifo_en         (fifo_en),
    .dma_mode        (dma_mode),
    .rx_trig_set     (rx_trig_set),
    .tx_space_set    (tx_space_set),
    .tx_thr_explicit (tx_thr_explicit),
    .tx_thr_set      (tx_thr_set),
    .rx_level        (rx_level),
    .tx_level        (tx_level),
    .rx_pop          (rx_pop),
    .tx_push         (tx_push),
    .rx_irq          (rx_irq),
    .tx_irq          (tx_irq),
    .rx_dma_req      (rx_dma_req),
    .tx_dma_req      (tx_dma_req)
  );

  // {rx_level, tx_level, expected rx_irq, expected tx_irq}
  // with receive trigger 8 and transmit space 16 and DMA mode 0.
  localparam logic [15:0] VEC [0:5] = '{
    {7'd0,  7'd0,  1'b0, 1'b1},
    {7'd7,  7'd15, 1'b0, 1'b1},
    {7'd8,  7'd16, 1'b1, 1'b0},
    {7'd64, 7'd64, 1'b1, 1'b0},
    {7'd9,  7'd1,  1'b1, 1'b1},
    {7'd7,  7'd17, 1'b0, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; dma_mode = 2'd0;
    rx_trig_set = 7'd8; tx_space_set = 7'd16; tx_thr_explicit = 1'b0; tx_thr_set = 7'd0;
    rx_level = 7'd0; tx_level = 7'd0; rx_pop = 1'b0; tx_push = 1'b0;
    repeat (3) tick();
    chk("R1 rx_irq in reset", rx_irq, 1'b0);
    chk("R1 tx_irq in reset", tx_irq, 1'b0);
    chk("R1 rx_dma_req in reset", rx_dma_req, 1'b0);
    chk("R1 tx_dma_req in reset", tx_dma_req, 1'b0);
    rst_n = 1'b1;

    // Single-character mode (R8), settings captured meanwhile.
    tick();
    chk("R8 tx_irq empty", tx_irq, 1'b1);
    chk("R8 rx_irq empty", rx_irq, 1'b0);
    chk("R9 tx_dma off", tx_dma_req, 1'b0);
    dma_mode = 2'd1; rx_level = 7'd1;
    tick();
    chk("R8 rx_irq one char", rx_irq, 1'b1);
    chk("R8 rx_dma one char", rx_dma_req, 1'b1);
    chk("R8 tx_dma empty", tx_dma_req, 1'b1);
    rx_pop = 1'b1;
    tick();
    chk("R8 rx_dma after one pop", rx_dma_req, 1'b0);
    rx_pop = 1'b0;
    tick();
    chk("R8 rx_dma re-raised", rx_dma_req, 1'b1);
    tx_push = 1'b1;
    tick();
    chk("R8 tx_dma after one push", tx_dma_req, 1'b0);
    tx_push = 1'b0; tx_level = 7'd1;
    tick();
    chk("R8 tx_dma not empty", tx_dma_req, 1'b0);
    chk("R8 tx_irq not empty", tx_irq, 1'b0);

    // Enable FIFOs with DMA silenced, then change a setting (R10).
    fifo_en = 1'b1; dma_mode = 2'd0;
    tick();
    rx_trig_set = 7'd2;
    for (int i = 0; i < 6; i++) begin
      rx_level = VEC[i][15:9];
      tx_level = VEC[i][8:2];
      tick();
      chk($sformatf("R2 rx_irq vector %0d", i), rx_irq, VEC[i][1]);
      chk($sformatf("R3 tx_irq vector %0d", i), tx_irq, VEC[i][0]);
      chk($sformatf("R9 rx_dma vector %0d", i), rx_dma_req, 1'b0);
      chk($sformatf("R9 tx_dma vector %0d", i), tx_dma_req, 1'b0);
    end
    rx_level = 7'd3;
    tick();
    chk("R10 trigger change ignored while enabled", rx_irq, 1'b0);

    // Receive DMA burst (R4): trigger 8.
    dma_mode = 2'd1; rx_level = 7'd5; tx_level = 7'd64;
    tick();
    chk("R4 rx_dma below trigger", rx_dma_req, 1'b0);
    rx_level = 7'd8;
    tick();
    chk("R4 rx_dma at trigger", rx_dma_req, 1'b1);
    chk("R5 tx_dma full fifo", tx_dma_req, 1'b0);
    rx_level = 7'd20; rx_pop = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      tick();
      chk($sformatf("R4 rx_dma held after pop %0d", i), rx_dma_req, 1'b1);
    end
    tick();
    chk("R4 rx_dma drops after 8 pops", rx_dma_req, 1'b0);
    rx_pop = 1'b0;
    tick();
    chk("R4 rx_dma re-raised", rx_dma_req, 1'b1);

    // Transmit DMA burst, derived threshold 64-16=48 (R5, R7).
    rx_level = 7'd0; tx_level = 7'd48;
    tick();
    chk("R5 tx_dma at threshold", tx_dma_req, 1'b0);
    tx_level = 7'd47;
    tick();
    chk("R5 tx_dma below threshold", tx_dma_req, 1'b1);
    tx_push = 1'b1;
    for (int i = 1; i <= 15; i++) begin
      tick();
      chk($sformatf("R7 tx_dma held after push %0d", i), tx_dma_req, 1'b1);
    end
    tick();
    chk("R7 tx_dma drops after 16 pushes", tx_dma_req, 1'b0);
    tx_push = 1'b0;
    tick();
    chk("R7 tx_dma re-raised", tx_dma_req, 1'b1);
    tx_level = 7'd60;
    tick();
    chk("R7 tx_dma held above threshold", tx_dma_req, 1'b1);

    // Explicit threshold 40 (R6, R12).
    fifo_en = 1'b0; tx_thr_explicit = 1'b1; tx_thr_set = 7'd40;
    tick();
    fifo_en = 1'b1;
    tick();
    chk("R12 tx_dma dropped on mode change", tx_dma_req, 1'b0);
    tx_level = 7'd40;
    tick();
    chk("R6 tx_dma at explicit threshold", tx_dma_req, 1'b0);
    tx_level = 7'd39;
    tick();
    chk("R6 tx_dma below explicit threshold", tx_dma_req, 1'b1);
    fifo_en = 1'b0; tx_thr_set = 7'd50; tx_level = 7'd63;
    tick();
    fifo_en = 1'b1;
    tick();
    chk("R6 clamped threshold 64", tx_dma_req, 1'b1);

    // Out-of-range trigger settings (R11) and DMA mode 0 (R9).
    fifo_en = 1'b0; rx_trig_set = 7'd0;
    tick();
    fifo_en = 1'b1; dma_mode = 2'd0; rx_level = 7'd1;
    tick();
    chk("R11 zero trigger acts as 1", rx_irq, 1'b1);
    chk("R9 rx_dma mode 0", rx_dma_req, 1'b0);
    chk("R9 tx_dma mode 0", tx_dma_req, 1'b0);
    fifo_en = 1'b0; rx_trig_set = 7'd100;
    tick();
    fifo_en = 1'b1; rx_level = 7'd63;
    tick();
    chk("R11 large trigger acts as 64 (63)", rx_irq, 1'b0);
    rx_level = 7'd64;
    tick();
    chk("R11 large trigger acts as 64 (64)", rx_irq, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule